// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block creates the system reset for a processor. It takes two hold conditions. The first is a supply-good flag that an external threshold comparator presents synchronously. The second is an active-low pushbutton line that may bounce. While either condition is active, reset stays asserted. When both have cleared, reset remains asserted for a fixed recovery interval, measured in clock cycles or in enable ticks, and then releases.

Every supply dip and every button press restarts the interval from zero. As a result, each assertion lasts the full interval, even if the cause was a single-cycle glitch. The pushbutton passes through a multi-flop synchroniser and needs no debounce, because the recovery interval absorbs any bounce. Parameters choose whether the active-low output, the active-high output, or both are driven. An output that is not driven is tied to its inactive level.

Top module: `rstgen_top`

## Requirements
- R1: A low `supply_ok_i` sampled at a rising edge makes the reset outputs active after that edge. They stay active for as long as `supply_ok_i` stays low.
- R2: A low on `btn_ni` makes the reset outputs active after the third rising edge that follows, because of the two synchroniser stages. A low lasting a single clock cycle is enough.
- R3: After the last edge at which a hold condition is seen, the reset stays active for exactly `RECOVERY_CYCLES` counting edges. It releases after the last of those edges.
- R4: A hold condition that arrives while the interval is running clears the count. Release then happens only after a full new interval that starts once the hold ends.
- R5: A supply dip seen at one single edge, starting from the released state, still produces an assertion of the full `RECOVERY_CYCLES` length.
- R6: While `por_ni` is low, reset is active and the count is zero. After `por_ni` rises with no hold condition present, release follows `RECOVERY_CYCLES` edges later.
- R7: When both outputs are enabled, `sys_rst_no` is the exact complement of `sys_rst_o`. An output that is disabled by parameter stays at its inactive level: 1 for `sys_rst_no`, 0 for `sys_rst_o`.
- R8: With `USE_TICK=1`, only edges with `tick_i` high advance the interval. Edges with `tick_i` low neither advance it nor release reset.
- R9: With `USE_TICK=0`, `tick_i` has no effect, and the interval counts every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_i | input | 1 | Synchronous supply-above-threshold flag |
| btn_ni | input | 1 | Asynchronous manual reset button, active low |
| tick_i | input | 1 | Count enable used when USE_TICK=1 |
| sys_rst_no | output | 1 | Active-low reset output |
| sys_rst_o | output | 1 | Active-high reset output |

## Verification
The hardest situation to reach is a hold condition that returns while the interval is partly counted. The restart is visible only because release comes later than it would have without the second hold. The stimulus lets the interval run for several cycles, drops the supply for one edge, and then checks that the outputs are still active one edge before a full fresh interval ends and released right at its end. Tick-gated counting is tested the same way: a long stretch with no ticks has to leave reset asserted.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
   typedef enum logic [1:0] {
      ST_HOLD  = 2'd0,
      ST_COUNT = 2'd1,
      ST_RUN   = 2'd2
   } rec_state_e;

   function automatic int cnt_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic async_i,
   output logic sync_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rstgen_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstgen_recovery.sv
module rstgen_recovery
   import rstgen_pkg::*;
#(
   parameter int RECOVERY_CYCLES = 200,
   parameter bit USE_TICK        = 1'b0
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic hold_i,
   input  logic tick_i,
   output logic active_o
);
   localparam int CNT_W = cnt_width(RECOVERY_CYCLES);
   localparam logic [CNT_W-1:0] TERM = CNT_W'(RECOVERY_CYCLES - 1);

   generate
      if (RECOVERY_CYCLES < 1) begin : g_bad
         $error("rstgen_recovery: RECOVERY_CYCLES must be at least 1");
      end
   endgenerate

   logic adv;
   generate
      if (USE_TICK) begin : g_tick
         assign adv = tick_i;
      end else begin : g_free
         assign adv = 1'b1 | tick_i;
      end
   endgenerate

   rec_state_e state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
      end else if (hold_i) begin
         state_q <= ST_HOLD;
         cnt_q   <= '0;
      end else if (state_q != ST_RUN && adv) begin
         if (cnt_q == TERM) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
         end else begin
            state_q <= ST_COUNT;
            cnt_q   <= cnt_q + CNT_W'(1);
         end
      end
   end

   assign active_o = (state_q != ST_RUN);

   // R1 / R4: any hold leaves the timer cleared on the next cycle
   assert_hold_clears_R1: assert property (@(posedge clk_i) disable iff (!por_ni)
      hold_i |=> (state_q == ST_HOLD && cnt_q == '0));

   // R3: release only after the terminal count on an advancing edge with no hold
   assert_release_full_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
      $fell(active_o) |-> ($past(cnt_q) == TERM && $past(adv) && !$past(hold_i)));

   assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!por_ni)
      cnt_q <= TERM);

   assert_idle_zero_R6: assert property (@(posedge clk_i) disable iff (!por_ni)
      (state_q == ST_RUN) |-> (cnt_q == '0));

   // R8: without an advance the timer does not move
   assert_no_adv_stable_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!adv && !hold_i) |=> ($stable(cnt_q) && $stable(state_q)));
endmodule

// File: rtl/rstgen_drive.sv
module rstgen_drive #(
   parameter bit EMIT_LOW  = 1'b1,
   parameter bit EMIT_HIGH = 1'b1
) (
   input  logic active_i,
   output logic rst_no,
   output logic rst_o
);
   generate
      if (!EMIT_LOW && !EMIT_HIGH) begin : g_bad
         $error("rstgen_drive: at least one output must be enabled");
      end
      if (EMIT_LOW) begin : g_low
         assign rst_no = ~active_i;
      end else begin : g_low_off
         assign rst_no = 1'b1;
      end
      if (EMIT_HIGH) begin : g_high
         assign rst_o = active_i;
      end else begin : g_high_off
         assign rst_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/rstgen_top.sv
module rstgen_top #(
   parameter int RECOVERY_CYCLES = 200,
   parameter int SYNC_STAGES     = 2,
   parameter bit USE_TICK        = 1'b0,
   parameter bit EMIT_LOW        = 1'b1,
   parameter bit EMIT_HIGH       = 1'b1
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic supply_ok_i,
   input  logic btn_ni,
   input  logic tick_i,
   output logic sys_rst_no,
   output logic sys_rst_o
);
   logic btn_sync_n;
   logic hold;
   logic active;

   rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .por_ni (por_ni),
      .async_i(btn_ni),
      .sync_o (btn_sync_n)
   );

   assign hold = !supply_ok_i || !btn_sync_n;

   rstgen_recovery #(
      .RECOVERY_CYCLES(RECOVERY_CYCLES),
      .USE_TICK       (USE_TICK)
   ) u_rec (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .hold_i  (hold),
      .tick_i  (tick_i),
      .active_o(active)
   );

   rstgen_drive #(.EMIT_LOW(EMIT_LOW), .EMIT_HIGH(EMIT_HIGH)) u_drv (
      .active_i(active),
      .rst_no  (sys_rst_no),
      .rst_o   (sys_rst_o)
   );

   // R1: an invalid supply always yields an active reset one cycle later
   assert_supply_asserts_R1: assert property (@(posedge clk_i) disable iff (!por_ni)
      !supply_ok_i |=> active);

   // R2: synchronised button low always yields an active reset one cycle later
   assert_button_asserts_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
      !btn_sync_n |=> active);
endmodule

// File: tb/tb_rstgen_top.sv
module tb_rstgen_top;
   localparam int N  = 20;
   localparam int NT = 4;

   logic clk = 1'b0;
   logic por_n, supply_ok, btn_n, tick_main;
   logic supply_t, tick_t;
   logic rst_n, rst_h, rst_t_n, rst_t_h;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #4 clk = ~clk;

   rstgen_top #(.RECOVERY_CYCLES(N)) dut (
      .clk_i(clk), .por_ni(por_n), .supply_ok_i(supply_ok), .btn_ni(btn_n),
      .tick_i(tick_main), .sys_rst_no(rst_n), .sys_rst_o(rst_h));

   rstgen_top #(.RECOVERY_CYCLES(NT), .USE_TICK(1'b1), .EMIT_HIGH(1'b0)) dut_tick (
      .clk_i(clk), .por_ni(por_n), .supply_ok_i(supply_t), .btn_ni(1'b1),
      .tick_i(tick_t), .sys_rst_no(rst_t_n), .sys_rst_o(rst_t_h));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // main instance: active means rst_h=1 and rst_n=0 (R7 complement)
   task automatic expect_main(input string req, input logic active);
      chk(req, rst_h, active);
      chk({req, "/R7"}, rst_n, ~active);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic t_por;
      por_n = 1'b0; supply_ok = 1'b1; btn_n = 1'b1; tick_main = 1'b0;
      supply_t = 1'b1; tick_t = 1'b0;
      step(2);
      expect_main("R6 during por", 1'b1);
      chk("R7 disabled high output", rst_t_h, 1'b0);
      chk("R6 tick instance during por", rst_t_n, 1'b0);
      por_n = 1'b1;
      step(N - 1);
      expect_main("R6 one edge before release", 1'b1);
      step(1);
      expect_main("R6 released after interval", 1'b0);
   endtask

   task automatic t_tick;
      step(10);
      chk("R8 no ticks keeps reset", rst_t_n, 1'b0);
      for (int k = 0; k < NT; k++) begin
         tick_t = 1'b1; step(1);
         tick_t = 1'b0;
         if (k == NT - 2) chk("R8 one tick short", rst_t_n, 1'b0);
         step(2);
      end
      chk("R8 released after ticks", rst_t_n, 1'b1);
      chk("R7 disabled high output stays low", rst_t_h, 1'b0);
   endtask

   task automatic t_supply;
      supply_ok = 1'b0; step(1);
      expect_main("R1 asserted after dip edge", 1'b1);
      step(5);
      expect_main("R1 held while invalid", 1'b1);
      supply_ok = 1'b1;
      step(N - 1);
      expect_main("R3 R9 one edge short", 1'b1);
      step(1);
      expect_main("R3 R9 released", 1'b0);
   endtask

   task automatic t_glitch;
      supply_ok = 1'b0; step(1); supply_ok = 1'b1;
      step(N - 1);
      expect_main("R5 glitch full pulse", 1'b1);
      step(1);
      expect_main("R5 glitch released", 1'b0);
   endtask

   task automatic t_restart;
      supply_ok = 1'b0; step(1); supply_ok = 1'b1;
      step(5);
      supply_ok = 1'b0; step(1); supply_ok = 1'b1;
      step(N - 6);
      expect_main("R4 original deadline passed, still held", 1'b1);
      step(5);
      expect_main("R4 one edge before restarted end", 1'b1);
      step(1);
      expect_main("R4 released after restart", 1'b0);
   endtask

   task automatic t_button;
      btn_n = 1'b0; step(2);
      expect_main("R2 sync latency not yet", 1'b0);
      step(1);
      expect_main("R2 asserted on third edge", 1'b1);
      step(3);
      btn_n = 1'b1; step(2);
      expect_main("R2 held through sync", 1'b1);
      step(N - 1);
      expect_main("R3 button one edge short", 1'b1);
      step(1);
      expect_main("R3 button released", 1'b0);
   endtask

   task automatic t_button_pulse;
      btn_n = 1'b0; step(1); btn_n = 1'b1;
      step(2);
      expect_main("R2 single-cycle press caught", 1'b1);
      step(N - 1);
      expect_main("R2 pulse full length", 1'b1);
      step(1);
      expect_main("R2 pulse released", 1'b0);
   endtask

   initial begin
      t_por();
      t_tick();
      t_supply();
      t_glitch();
      t_restart();
      t_button();
      t_button_pulse();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule